// File: doc/BRIEF.md
# Multi-Mode Buzzer Tone Generator

This block turns a system clock into a square-wave drive for a piezo buzzer. A 3-bit code picks one of eight tone pitches between 0.625 kHz and 3 kHz, and a 2-bit code picks the envelope that gates the tone. The envelopes are: steady tone, a single 50 ms burst started by a trigger pulse, a 10 Hz on/off pattern, and the same 10 Hz pattern confined to the first half of every second. All pitch and gating rates are derived inside the block from the `CLK_HZ` parameter.

When the enable input is high the gating timers run from the moment it rose. When it is low, every timer restarts and the output sits low. Whenever the envelope is in an off phase, the tone divider is cleared, so each burst starts from a low level.

Top module: `buzzer_tone_gen`

## Requirements
- R1: While `enable` is low, `buzzOut` is low one cycle later and all gating timers restart, so a later rise of `enable` begins a fresh envelope.
- R2: `freqSel` codes 0 to 7 select 625, 1000, 1250, 1500, 2000, 2500, 2700 and 3000 Hz. The output toggles every floor(CLK_HZ / (2*f)) cycles, so a full period lasts twice that.
- R3: With `mode` = 0 (steady), the tone runs without a gap for as long as `enable` is high.
- R4: With `mode` = 1 (single), the output is silent until `trigger` is seen high. The tone then runs for CLK_HZ/20 cycles (50 ms) and stops.
- R5: A `trigger` seen while a single burst is running does not lengthen it. A `trigger` seen in any mode other than 1 starts no burst.
- R6: With `mode` = 2 (intermittent), the envelope repeats every CLK_HZ/10 cycles. It plays the tone for the first CLK_HZ/20 cycles after `enable` rose and is silent for the second CLK_HZ/20 cycles.
- R7: With `mode` = 3, the R6 pattern applies during the first CLK_HZ/2 cycles of each CLK_HZ-cycle second counted from the rise of `enable`. The output is silent for the remaining half second.
- R8: In any off phase of the envelope, `buzzOut` is low one cycle later. `buzzOut` can rise only after a cycle in which the envelope allowed the tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ cycles per second |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator; low forces silence and restarts the timers |
| freqSel | input | 3 | Tone pitch code |
| mode | input | 2 | Envelope: 0 steady, 1 single, 2 intermittent, 3 intermittent in the first half second |
| trigger | input | 1 | Starts a single burst in mode 1 |
| buzzOut | output | 1 | Square-wave buzzer drive |

## Verification
Some properties are checked on every cycle. The output falls one cycle after `enable` drops or after the envelope closes. It rises only after a cycle in which the envelope allowed the tone. No unbroken run of allowed tone cycles in modes 1 to 3 lasts longer than 50 ms. The exact tone period for each code, the on/off placement of the 10 Hz and 1 Hz patterns relative to `enable`, and the handling of a second trigger are shown only by the bench's timed scenarios, which measure output edges inside known windows.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

  typedef enum logic [1:0] {
    MODE_STEADY    = 2'd0,
    MODE_SHOT      = 2'd1,
    MODE_PULSE     = 2'd2,
    MODE_PULSE_SEC = 2'd3
  } envMode_e;

  localparam int NUM_TONES = 8;

  // Strobes from the envelope control to the tone datapath
  typedef struct packed {
    logic       run;
    logic [2:0] freqSel;
  } toneCtl_t;

  function automatic int toneHz(input int code);
    case (code)
      0: return 625;
      1: return 1000;
      2: return 1250;
      3: return 1500;
      4: return 2000;
      5: return 2500;
      6: return 2700;
      default: return 3000;
    endcase
  endfunction

  function automatic int halfPeriod(input int clkHz, input int code);
    return clkHz / (2 * toneHz(code));
  endfunction

endpackage

// File: rtl/buzz_ctrl.sv
module buzz_ctrl
  import buzz_pkg::*;
#(
  parameter int CLK_HZ = 12_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic [2:0] freqSel,
  input  logic       trigger,
  output toneCtl_t   ctl
);

  localparam int GATE_HALF = CLK_HZ / 20;
  localparam int GATE_W    = $clog2(2 * GATE_HALF);
  localparam int SEC_W     = $clog2(CLK_HZ);

  localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(2 * GATE_HALF - 1);
  localparam logic [GATE_W-1:0] GATE_MID  = GATE_W'(GATE_HALF);
  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(CLK_HZ - 1);
  localparam logic [SEC_W-1:0]  SEC_MID   = SEC_W'(CLK_HZ / 2);

  logic [GATE_W-1:0] gateCnt;
  logic [SEC_W-1:0]  secCnt;
  logic [GATE_W-1:0] shotCnt;
  logic              gateOn;
  logic              firstHalf;
  logic              shotOn;
  envMode_e          modeSel;

  assign modeSel = envMode_e'(mode);

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      gateCnt <= '0;
      secCnt  <= '0;
      shotCnt <= '0;
    end else begin
      gateCnt <= (gateCnt == GATE_LAST) ? '0 : gateCnt + 1'b1;
      secCnt  <= (secCnt == SEC_LAST) ? '0 : secCnt + 1'b1;
      if (shotCnt != '0)
        shotCnt <= shotCnt - 1'b1;
      else if (trigger && modeSel == MODE_SHOT)
        shotCnt <= GATE_MID;
    end
  end

  assign gateOn    = gateCnt < GATE_MID;
  assign firstHalf = secCnt < SEC_MID;
  assign shotOn    = shotCnt != '0;

  always_comb begin
    ctl.freqSel = freqSel;
    unique case (modeSel)
      MODE_STEADY:    ctl.run = enable;
      MODE_SHOT:      ctl.run = enable && shotOn;
      MODE_PULSE:     ctl.run = enable && gateOn;
      MODE_PULSE_SEC: ctl.run = enable && gateOn && firstHalf;
      default:        ctl.run = 1'b0;
    endcase
  end

endmodule

// File: rtl/buzz_tone_dp.sv
module buzz_tone_dp
  import buzz_pkg::*;
#(
  parameter int CLK_HZ = 12_000_000
) (
  input  logic     clk,
  input  logic     rstN,
  input  toneCtl_t ctl,
  output logic     toneOut
);

  localparam int CNT_W = $clog2(halfPeriod(CLK_HZ, 0) + 1);

  logic [CNT_W-1:0] halfTbl [NUM_TONES];
  logic [CNT_W-1:0] toneCnt;
  logic [CNT_W:0]   nextCnt;
  logic             lastStep;

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_half
    assign halfTbl[g] = CNT_W'(halfPeriod(CLK_HZ, g));
  end

  assign nextCnt  = {1'b0, toneCnt} + 1'b1;
  assign lastStep = nextCnt >= {1'b0, halfTbl[ctl.freqSel]};

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.run) begin
      toneCnt <= '0;
      toneOut <= 1'b0;
    end else if (lastStep) begin
      toneCnt <= '0;
      toneOut <= ~toneOut;
    end else begin
      toneCnt <= nextCnt[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/buzzer_tone_gen.sv
module buzzer_tone_gen
  import buzz_pkg::*;
#(
  parameter int CLK_HZ = 12_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [2:0] freqSel,
  input  logic [1:0] mode,
  input  logic       trigger,
  output logic       buzzOut
);

  toneCtl_t ctlBus;

  buzz_ctrl #(.CLK_HZ(CLK_HZ)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .mode    (mode),
    .freqSel (freqSel),
    .trigger (trigger),
    .ctl     (ctlBus)
  );

  buzz_tone_dp #(.CLK_HZ(CLK_HZ)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctlBus),
    .toneOut (buzzOut)
  );

endmodule

// File: rtl/buzz_check.sv
module buzz_check #(
  parameter int CLK_HZ = 12_000_000
) (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic [1:0] mode,
  input logic       ctlRun,
  input logic       buzzOut
);

  localparam int GATE_HALF = CLK_HZ / 20;
  localparam int LEN_W     = $clog2(GATE_HALF + 2) + 1;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(GATE_HALF);

  logic [LEN_W-1:0] runLen;
  logic [1:0]       prevMode;

  // Length of the current unbroken run of tone-allowed cycles in a gated mode
  always_ff @(posedge clk) begin
    prevMode <= mode;
    if (!rstN || !ctlRun || mode == 2'd0 || mode != prevMode)
      runLen <= '0;
    else if (runLen <= LEN_MAX)
      runLen <= runLen + 1'b1;
  end

  a_r1_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !buzzOut);

  a_r8_gated_low: assert property (@(posedge clk) disable iff (!rstN)
    !ctlRun |=> !buzzOut);

  a_r8_rise_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(buzzOut) |-> $past(ctlRun));

  // R4 and R6/R7: no burst longer than one 50 ms window
  a_r4_burst_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd1) |-> (runLen <= LEN_MAX));

  a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (mode[1]) |-> (runLen <= LEN_MAX));

endmodule

bind buzzer_tone_gen buzz_check #(.CLK_HZ(CLK_HZ)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .mode    (mode),
  .ctlRun  (ctlBus.run),
  .buzzOut (buzzOut)
);

// File: tb/buzzer_tone_gen_test.sv
module buzzer_tone_gen_test;

  localparam int CLK_HZ = 60_000;   // scaled-down rate: 1 s = 60000 cycles

  typedef struct packed {
    logic [2:0]  sel;
    logic [1:0]  md;
    logic [15:0] period;
  } vec_t;

  // R2: full period = 2*floor(60000/(2f))
  localparam vec_t VECS [10] = '{
    '{3'd0, 2'd0, 16'd96}, '{3'd1, 2'd0, 16'd60}, '{3'd2, 2'd0, 16'd48},
    '{3'd3, 2'd0, 16'd40}, '{3'd4, 2'd0, 16'd30}, '{3'd5, 2'd0, 16'd24},
    '{3'd6, 2'd0, 16'd22}, '{3'd7, 2'd0, 16'd20}, '{3'd7, 2'd2, 16'd20},
    '{3'd0, 2'd2, 16'd96}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] freqSel = 3'd0;
  logic [1:0] mode = 2'd0;
  logic       trigger = 1'b0;
  logic       buzzOut;

  int cyc = 0;
  int base = 0;
  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  buzzer_tone_gen #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .freqSel(freqSel),
    .mode(mode), .trigger(trigger), .buzzOut(buzzOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic startRun(input logic [2:0] sel, input logic [1:0] md);
    @(negedge clk);
    enable = 1'b0;
    repeat (5) @(negedge clk);
    freqSel = sel;
    mode = md;
    enable = 1'b1;
    base = cyc;
  endtask

  task automatic window(input int from, input int to, input bit active, input string req);
    int rises = 0;
    int highs = 0;
    logic prev;
    waitUntil(base + from);
    prev = buzzOut;
    while (cyc < base + to) begin
      @(negedge clk);
      if (buzzOut && !prev) rises++;
      if (buzzOut) highs++;
      prev = buzzOut;
    end
    if (active) check(rises > 0, req, rises, 1);
    else        check(highs == 0, req, highs, 0);
  endtask

  task automatic measurePeriod(output int period);
    logic prev;
    int t0;
    int guard;
    period = -1;
    t0 = -1;
    guard = 0;
    @(negedge clk);
    prev = buzzOut;
    while (guard < 1000 && period < 0) begin
      @(negedge clk);
      guard++;
      if (buzzOut && !prev) begin
        if (t0 < 0) t0 = cyc;
        else period = cyc - t0;
      end
      prev = buzzOut;
    end
  endtask

  task automatic pulseTrigger();
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    base = cyc - 1;
  endtask

  initial begin
    #(200_000 * 5);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    int per;
    int rises;
    logic prev;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (50) @(negedge clk);
    check(buzzOut == 1'b0, "R1 reset/disabled low", int'(buzzOut), 0);

    // Vector table: R2 pitch codes, steady and intermittent envelopes
    foreach (VECS[i]) begin
      startRun(VECS[i].sel, VECS[i].md);
      measurePeriod(per);
      check(per == int'(VECS[i].period), $sformatf("R2 period code %0d mode %0d", VECS[i].sel, VECS[i].md),
            per, int'(VECS[i].period));
    end

    // R3: steady tone has no gap over 6000 cycles (period 20 -> 300 rises)
    startRun(3'd7, 2'd0);
    waitUntil(base + 100);
    rises = 0;
    @(negedge clk);
    prev = buzzOut;
    repeat (6000) begin
      @(negedge clk);
      if (buzzOut && !prev) rises++;
      prev = buzzOut;
    end
    check(rises >= 299 && rises <= 301, "R3 steady tone rises", rises, 300);

    // R1: dropping enable silences the output next cycle
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(buzzOut == 1'b0, "R1 low after disable", int'(buzzOut), 0);
    base = cyc;
    window(1, 60, 1'b0, "R1 stays low while disabled");

    // R6: 10 Hz intermittent from the rise of enable
    startRun(3'd4, 2'd2);
    window(100, 2900, 1'b1, "R6 first on-phase");
    window(3100, 5900, 1'b0, "R6 first off-phase");
    window(6100, 8900, 1'b1, "R6 second on-phase");

    // R4: single burst
    startRun(3'd3, 2'd1);
    window(100, 1000, 1'b0, "R4 silent before trigger");
    pulseTrigger();
    window(100, 2900, 1'b1, "R4 burst after trigger");
    window(3100, 6000, 1'b0, "R4 silent after burst");

    // R5: retrigger during burst does not extend it
    pulseTrigger();
    waitUntil(base + 2000);
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    window(3100, 4900, 1'b0, "R5 retrigger ignored");

    // R5: trigger in steady mode starts no burst after switching to single
    startRun(3'd3, 2'd0);
    pulseTrigger();
    @(negedge clk);
    mode = 2'd1;
    base = cyc;
    window(2, 2000, 1'b0, "R5 trigger outside mode 1 ignored");

    // R7: intermittent bursts in the first half of each second
    startRun(3'd5, 2'd3);
    window(100, 2900, 1'b1, "R7 first burst");
    window(3100, 5900, 1'b0, "R7 off-phase of 10 Hz");
    window(6100, 8900, 1'b1, "R7 second burst");
    window(30100, 32900, 1'b0, "R7 silent second half (R8)");
    window(60100, 62900, 1'b1, "R7 next second resumes");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule